// File: doc/BRIEF.md
# LPC Memory Cycle Host

This block is the bus-owning side of an LPC link. It turns a single request (a 32-bit address, a read or write flag, and a write byte) into one complete single-byte memory transaction on the four-bit multiplexed bus. It drives the frame strobe and the outgoing nibbles, hands the bus to the target and takes it back, and follows the target's handshake for as long as the target asks it to wait.

A request is a one-clock start pulse given while the block is idle. The block then walks through these phases in order: start, cycle type, address, optional write data, a two-clock turnaround, SYNC polling, optional read data, and the target's turnaround. It ends with a one-clock done pulse. The read byte and the error and timeout flags are valid with that pulse and stay until the next request. If the target stalls, or answers with an unknown SYNC code, the host stops the cycle by holding the frame strobe low for several clocks.

Top module: `lpc_mem_host`

## Requirements
- R1: On the clock after an accepted start pulse, `frame_n_o` is low for exactly one clock, while `bus_out_o` = 4'b0000 and `bus_oe_o` = 1.
- R2: On the next clock, `frame_n_o` is high and `bus_out_o` carries the cycle type: 4'b0100 for a read, 4'b0110 for a write.
- R3: The next eight clocks carry the address one nibble per clock, bits [31:28] first and bits [3:0] last.
- R4: A write then sends data bits [3:0] and then bits [7:4] on two clocks. A read sends no data nibbles.
- R5: The host turnaround follows. For one clock the host drives 4'b1111 with `bus_oe_o` = 1, and on the next clock `bus_oe_o` = 0.
- R6: Each following clock samples `bus_in_i` as SYNC. The code 4'b0101 means wait and is accepted any number of times below the limit. The code 4'b0000 means ready. For a read, the byte is taken from the two clocks after ready, low nibble first.
- R7: After the ready SYNC (write) or after the second data nibble (read), `bus_oe_o` stays 0 for two clocks. On the clock after that, the host drives again with `bus_oe_o` = 1 and `bus_out_o` = 4'b1111.
- R8: If the first `SYNC_LIMIT` SYNC samples are all 4'b0101, the host aborts. It holds `frame_n_o` low with 4'b1111 driven for `ABORT_CLKS` clocks, then pulses done with `timeout_o` = 1 and `err_o` = 0.
- R9: A SYNC code other than 4'b0101 or 4'b0000 causes the same abort sequence, ending with `err_o` = 1 and `timeout_o` = 0.
- R10: `done_o` is high for exactly one clock, on the clock after the last target-turnaround clock or the last abort clock. `rdata_o`, `err_o` and `timeout_o` are valid then and hold until the next accepted request.
- R11: `busy_o` is high from the clock after an accepted start through the done clock. A start pulse while busy has no effect on the transaction in progress.
- R12: After reset: `frame_n_o` = 1, `bus_oe_o` = 1, `bus_out_o` = 4'b1111, `done_o` = 0, `busy_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start_i | input | 1 | One-clock request pulse, taken only when idle |
| req_write_i | input | 1 | 1 = memory write, 0 = memory read |
| req_addr_i | input | 32 | Byte address of the transfer |
| req_wdata_i | input | 8 | Byte to write |
| bus_in_i | input | 4 | Nibble seen on the shared bus |
| bus_out_o | output | 4 | Nibble the host drives |
| bus_oe_o | output | 1 | Output enable for `bus_out_o` |
| frame_n_o | output | 1 | Active-low frame strobe |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Byte read from the target |
| err_o | output | 1 | Cycle ended on an unknown SYNC code |
| timeout_o | output | 1 | Cycle ended because no ready SYNC arrived in time |

## Verification
The hardest cases to reach are the edges of the SYNC window: exactly `SYNC_LIMIT`-1 wait codes followed by ready must succeed, and `SYNC_LIMIT` wait codes must abort. The bench acts as the target. It counts SYNC clocks on its own and chooses each returned nibble, so directed transactions place ready at the last allowed sample and just after it. Random transactions add wait counts across and beyond the limit, along with occasional bad SYNC codes. A directed case also pulses start in the middle of a cycle to show that the pulse is ignored.

// File: rtl/lpc_host_pkg.sv
// Shared phase encoding and bus nibble codes for the LPC memory host.
// Assumes a single-byte memory cycle; no other cycle kinds are encoded.
package lpc_host_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_CTYPE,
        PH_ADDR,
        PH_WLO,
        PH_WHI,
        PH_HTAR0,
        PH_HTAR1,
        PH_SYNC,
        PH_RLO,
        PH_RHI,
        PH_TTAR0,
        PH_TTAR1,
        PH_ABORT,
        PH_DONE
    } phase_t;

    localparam logic [3:0] NIB_START   = 4'b0000;
    localparam logic [3:0] NIB_CT_RD   = 4'b0100;
    localparam logic [3:0] NIB_CT_WR   = 4'b0110;
    localparam logic [3:0] NIB_PARK    = 4'b1111;
    localparam logic [3:0] SYNC_READY  = 4'b0000;
    localparam logic [3:0] SYNC_WAIT   = 4'b0101;

endpackage

// File: rtl/lpc_host_span_cnt.sv
// Clock-span counter: counts enabled clocks since the last clear and flags
// the clock on which LIMIT clocks have been seen (LIMIT-th enabled clock).
// Assumes LIMIT >= 1; saturates at the hit value.
module lpc_host_span_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic hit_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    // Hit marks the last clock of the span.
    assign hit_o = (cnt == CW'(LIMIT - 1));

    // Count enabled clocks, cleared on request and held at the hit value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (en_i && !hit_o) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lpc_host_nibsel.sv
// Outgoing nibble selector: picks the nibble the host drives for the current
// phase. Address nibbles are indexed by idx_i (ADDR_NIBS-1 = most significant).
// Assumes the caller gates the result with its own output enable.
module lpc_host_nibsel
    import lpc_host_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  phase_t             phase_i,
    input  logic               write_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [7:0]         wdata_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [3:0]         nib_o
);
    // Phase-driven nibble multiplexer.
    always_comb begin
        unique case (phase_i)
            PH_START: nib_o = NIB_START;
            PH_CTYPE: nib_o = write_i ? NIB_CT_WR : NIB_CT_RD;
            PH_ADDR:  nib_o = addr_i[{idx_i, 2'b00} +: 4];
            PH_WLO:   nib_o = wdata_i[3:0];
            PH_WHI:   nib_o = wdata_i[7:4];
            default:  nib_o = NIB_PARK;
        endcase
    end
endmodule

// File: rtl/lpc_mem_host.sv
// LPC memory cycle host: runs one single-byte memory read or write per
// request, polls SYNC for up to SYNC_LIMIT clocks and aborts on timeout or on
// an unknown SYNC code. Assumes req_* inputs are stable in the start clock.
module lpc_mem_host
    import lpc_host_pkg::*;
#(
    parameter int SYNC_LIMIT = 16,
    parameter int ABORT_CLKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start_i,
    input  logic        req_write_i,
    input  logic [31:0] req_addr_i,
    input  logic [7:0]  req_wdata_i,
    input  logic [3:0]  bus_in_i,
    output logic [3:0]  bus_out_o,
    output logic        bus_oe_o,
    output logic        frame_n_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [7:0]  rdata_o,
    output logic        err_o,
    output logic        timeout_o
);
    localparam int ADDR_W    = 32;
    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int IDX_W     = $clog2(ADDR_NIBS);

    phase_t              phase;
    logic                wr_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          wdata_q;
    logic [IDX_W-1:0]    idx_q;
    logic                sync_last;
    logic                abort_last;
    logic [3:0]          nib;

    // Limit on SYNC polling clocks.
    lpc_host_span_cnt #(.LIMIT(SYNC_LIMIT)) u_sync_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase != PH_SYNC),
        .en_i  (phase == PH_SYNC),
        .hit_o (sync_last)
    );

    // Length of the abort frame.
    lpc_host_span_cnt #(.LIMIT(ABORT_CLKS)) u_abort_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase != PH_ABORT),
        .en_i  (phase == PH_ABORT),
        .hit_o (abort_last)
    );

    lpc_host_nibsel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_nibsel (
        .phase_i (phase),
        .write_i (wr_q),
        .addr_i  (addr_q),
        .wdata_i (wdata_q),
        .idx_i   (idx_q),
        .nib_o   (nib)
    );

    // Phase sequencing, request capture, read data and status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            wr_q      <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            idx_q     <= '0;
            rdata_o   <= '0;
            err_o     <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_start_i) begin
                        wr_q      <= req_write_i;
                        addr_q    <= req_addr_i;
                        wdata_q   <= req_wdata_i;
                        err_o     <= 1'b0;
                        timeout_o <= 1'b0;
                        phase     <= PH_START;
                    end
                end
                PH_START: phase <= PH_CTYPE;
                PH_CTYPE: begin
                    idx_q <= IDX_W'(ADDR_NIBS - 1);
                    phase <= PH_ADDR;
                end
                PH_ADDR: begin
                    if (idx_q == '0) begin
                        phase <= wr_q ? PH_WLO : PH_HTAR0;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                PH_WLO:   phase <= PH_WHI;
                PH_WHI:   phase <= PH_HTAR0;
                PH_HTAR0: phase <= PH_HTAR1;
                PH_HTAR1: phase <= PH_SYNC;
                PH_SYNC: begin
                    if (bus_in_i == SYNC_READY) begin
                        phase <= wr_q ? PH_TTAR0 : PH_RLO;
                    end else if (bus_in_i == SYNC_WAIT) begin
                        if (sync_last) begin
                            timeout_o <= 1'b1;
                            phase     <= PH_ABORT;
                        end
                    end else begin
                        err_o <= 1'b1;
                        phase <= PH_ABORT;
                    end
                end
                PH_RLO: begin
                    rdata_o[3:0] <= bus_in_i;
                    phase        <= PH_RHI;
                end
                PH_RHI: begin
                    rdata_o[7:4] <= bus_in_i;
                    phase        <= PH_TTAR0;
                end
                PH_TTAR0: phase <= PH_TTAR1;
                PH_TTAR1: phase <= PH_DONE;
                PH_ABORT: if (abort_last) phase <= PH_DONE;
                PH_DONE:  phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // Bus pin drive: the host owns the bus except while the target talks.
    always_comb begin
        bus_out_o = nib;
        frame_n_o = !((phase == PH_START) || (phase == PH_ABORT));
        bus_oe_o  = !((phase == PH_HTAR1) || (phase == PH_SYNC) ||
                      (phase == PH_RLO)   || (phase == PH_RHI)  ||
                      (phase == PH_TTAR0) || (phase == PH_TTAR1));
        busy_o    = (phase != PH_IDLE);
        done_o    = (phase == PH_DONE);
    end
endmodule

// File: rtl/lpc_mem_host_chk.sv
// Protocol checker for lpc_mem_host, observing its ports only.
// Assumes synchronous active-low reset on rst_n.
module lpc_mem_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] bus_out_o,
    input logic       bus_oe_o,
    input logic       frame_n_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic       timeout_o
);
    // Frame opening from idle carries the start nibble.
    p_start_nib_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n_o) && $past(!busy_o)) |-> (bus_out_o == 4'h0 && bus_oe_o));

    // Host releases the bus only after parking it at all ones.
    p_park_before_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe_o) |-> ($past(bus_out_o) == 4'hF));

    // Done lasts a single clock.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Host owns the bus again when it reports done.
    p_retake_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bus_oe_o && frame_n_o));

    // A failed cycle was preceded by at least four clocks of low frame.
    p_abort_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (err_o || timeout_o)) |->
            ($past(!frame_n_o, 1) && $past(!frame_n_o, 2) &&
             $past(!frame_n_o, 3) && $past(!frame_n_o, 4)));

    // Error and timeout never report together.
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(err_o && timeout_o));

    // Busy covers the done clock.
    p_busy_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
endmodule

bind lpc_mem_host lpc_mem_host_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_out_o (bus_out_o),
    .bus_oe_o  (bus_oe_o),
    .frame_n_o (frame_n_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .timeout_o (timeout_o)
);

// File: tb/lpc_mem_host_test.sv
// Bench: acts as the LPC target, checks every bus clock against a model
// derived from the requirements. Directed edge cases plus seeded random.
module lpc_mem_host_test;
    localparam int LIMIT = 16;
    localparam int ABRT  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [7:0]  req_wdata_i = '0;
    logic [3:0]  bus_in_i = 4'hF;
    logic [3:0]  bus_out_o;
    logic        bus_oe_o, frame_n_o, busy_o, done_o, err_o, timeout_o;
    logic [7:0]  rdata_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    lpc_mem_host #(.SYNC_LIMIT(LIMIT), .ABORT_CLKS(ABRT)) uut (
        .clk(clk), .rst_n(rst_n), .req_start_i(req_start_i),
        .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .bus_in_i(bus_in_i),
        .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o), .frame_n_o(frame_n_o),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .err_o(err_o), .timeout_o(timeout_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected outcome code: 0 ok, 1 timeout, 2 error.
    function automatic int outcome(input int nwait, input logic [3:0] code);
        if (nwait >= LIMIT) return 1;
        if (code == 4'h0) return 0;
        if (code == 4'h5) return 1;
        return 2;
    endfunction

    task automatic run_txn(input bit wr, input logic [31:0] a, input logic [7:0] wd,
                           input logic [7:0] rd, input int nwait,
                           input logic [3:0] code, input bit poke);
        int res;
        int nsamp;
        res   = outcome(nwait, code);
        nsamp = (nwait >= LIMIT) ? LIMIT : nwait + 1;
        @(negedge clk);
        req_start_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = wd;
        @(negedge clk);
        req_start_i = poke;
        if (poke) begin
            req_addr_i = ~a; req_write_i = ~wr; req_wdata_i = ~wd;
        end
        chk(frame_n_o == 1'b0 && bus_out_o == 4'h0 && bus_oe_o, "R1 start",
            {27'd0, frame_n_o, bus_out_o}, 32'h0);
        chk(busy_o == 1'b1, "R11 busy", {31'd0, busy_o}, 32'd1);
        @(negedge clk);
        req_start_i = 1'b0;
        chk(frame_n_o && bus_out_o == (wr ? 4'h6 : 4'h4), "R2 cycle type",
            {27'd0, frame_n_o, bus_out_o}, {27'd0, 1'b1, (wr ? 4'h6 : 4'h4)});
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            chk(bus_out_o == a[i*4 +: 4] && bus_oe_o && frame_n_o, "R3 R11 address nibble",
                {28'd0, bus_out_o}, {28'd0, a[i*4 +: 4]});
        end
        if (wr) begin
            @(negedge clk);
            chk(bus_out_o == wd[3:0], "R4 write low", {28'd0, bus_out_o}, {28'd0, wd[3:0]});
            @(negedge clk);
            chk(bus_out_o == wd[7:4], "R4 write high", {28'd0, bus_out_o}, {28'd0, wd[7:4]});
        end
        @(negedge clk);
        chk(bus_out_o == 4'hF && bus_oe_o, "R5 park", {27'd0, bus_oe_o, bus_out_o}, 32'h1F);
        @(negedge clk);
        chk(!bus_oe_o, "R5 release", {31'd0, bus_oe_o}, 32'd0);
        for (int k = 0; k < nsamp; k++) begin
            @(negedge clk);
            bus_in_i = (k < nwait) ? 4'h5 : code;
            chk(!bus_oe_o && frame_n_o && !done_o, "R6 sync poll",
                {29'd0, bus_oe_o, frame_n_o, done_o}, 32'd2);
        end
        if (res != 0) begin
            for (int j = 0; j < ABRT; j++) begin
                @(negedge clk);
                bus_in_i = 4'hF;
                chk(!frame_n_o && bus_oe_o && bus_out_o == 4'hF && !done_o,
                    (res == 1) ? "R8 abort frame" : "R9 abort frame",
                    {26'd0, frame_n_o, bus_oe_o, bus_out_o}, 32'h1F);
            end
        end else begin
            if (!wr) begin
                @(negedge clk);
                bus_in_i = rd[3:0];
                @(negedge clk);
                bus_in_i = rd[7:4];
            end
            for (int j = 0; j < 2; j++) begin
                @(negedge clk);
                bus_in_i = 4'hF;
                chk(!bus_oe_o && !done_o, "R7 target turnaround",
                    {30'd0, bus_oe_o, done_o}, 32'd0);
            end
        end
        @(negedge clk);
        chk(done_o && busy_o, "R10 done", {30'd0, done_o, busy_o}, 32'd3);
        chk(bus_oe_o && bus_out_o == 4'hF && frame_n_o, "R7 host retakes bus",
            {27'd0, bus_oe_o, bus_out_o}, 32'h1F);
        chk(timeout_o == (res == 1), "R8 timeout flag", {31'd0, timeout_o}, {31'd0, res == 1});
        chk(err_o == (res == 2), "R9 error flag", {31'd0, err_o}, {31'd0, res == 2});
        if (res == 0 && !wr)
            chk(rdata_o == rd, "R6 read data", {24'd0, rdata_o}, {24'd0, rd});
        @(negedge clk);
        chk(!done_o && !busy_o, "R10 single done", {30'd0, done_o, busy_o}, 32'd0);
        chk(timeout_o == (res == 1) && err_o == (res == 2), "R10 flags held",
            {30'd0, err_o, timeout_o}, {30'd0, res == 2, res == 1});
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(frame_n_o && bus_oe_o && bus_out_o == 4'hF && !done_o && !busy_o,
            "R12 reset state", {25'd0, frame_n_o, bus_oe_o, bus_out_o, done_o, busy_o},
            32'h7C);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(1'b0, 32'h1234_5678, 8'h00, 8'hA5, 0, 4'h0, 1'b0);
        run_txn(1'b1, 32'hFEDC_BA98, 8'h3C, 8'h00, 0, 4'h0, 1'b0);
        run_txn(1'b0, 32'h8000_0001, 8'h00, 8'h96, LIMIT - 1, 4'h0, 1'b0);
        run_txn(1'b1, 32'h0F0F_F0F0, 8'h81, 8'h00, LIMIT - 1, 4'h0, 1'b0);
        run_txn(1'b0, 32'hDEAD_BEEF, 8'h00, 8'h11, LIMIT, 4'h0, 1'b0);
        run_txn(1'b0, 32'h0000_0010, 8'h00, 8'h22, 3, 4'hF, 1'b0);
        run_txn(1'b1, 32'hCAFE_0042, 8'h7E, 8'h00, 2, 4'h6, 1'b0);
        run_txn(1'b0, 32'h5555_AAAA, 8'h00, 8'hC3, 1, 4'h0, 1'b1);
        for (int t = 0; t < 80; t++) begin
            logic [3:0] code;
            int nw;
            nw = (($urandom % 6) == 0) ? (LIMIT + ($urandom % 3)) : ($urandom % LIMIT);
            code = 4'h0;
            if (($urandom % 7) == 0) begin
                do code = 4'($urandom); while (code == 4'h0 || code == 4'h5);
            end
            run_txn(1'($urandom), $urandom, 8'($urandom), 8'($urandom), nw, code,
                    (($urandom % 5) == 0));
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule